// File: doc/BRIEF.md
# Cached Ring FIFO

This block is a small bounded first-in first-out queue. Its storage is split in two parts: a head register that always holds the oldest item, and a ring of one-place storage cells that holds everything queued behind it. Because the oldest item sits in the head register, the output port presents it directly, with no storage access on the output path.

Items enter on a valid/ready input port and leave on a valid/ready output port. The controller reaches each ring cell through its own write request/acknowledge pair and its own read request/acknowledge pair. It keeps an occupancy count, a write pointer and a read pointer. Both pointers step through the cells 1, 2, 3 and wrap from the last back to the first. Total capacity is one more than the number of ring cells: four items with the default of three cells. The data path is 2 bits wide.

When the queue is empty, an arriving item goes straight to the head register. When an item is taken and more remain, the next one is fetched from the ring into the head register. If an output and an input could both happen in one cycle, the output goes first. The input waits until any cell exchange that the output started has finished.

Top module: `cached_ring_fifo`

## Requirements
- R1: After reset the queue is empty: out_valid is 0 and in_ready is 1.
- R2: Items leave in the order they were accepted, with unchanged values, across any number of pointer wraps.
- R3: Occupancy never exceeds 4 (ring cells plus one). While 4 items are held, in_ready is 0. A fifth item is taken only after an output transfer.
- R4: An item accepted into an empty queue is offered on out_valid/out_data in the very next cycle.
- R5: out_valid is 0 whenever the queue holds no item, so no transfer can underflow.
- R6: In a cycle where an output transfer happens (out_valid and out_ready both 1), in_ready is 0.
- R7: Taking an output while more than one item is held drops out_valid and in_ready for exactly 2 cycles. The next item is then offered. Taking the last item needs no cell access.
- R8: Accepting an input into a non-empty queue drops in_ready and out_valid for exactly 2 cycles. The head item stays offered afterwards.
- R9: While out_valid is 1 and out_ready is 0, out_data holds its value into the next cycle.
- R10: Each ring cell accepts a write only while empty and a read only while holding an item, and acknowledges one cycle after the request. At most one cell is addressed at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers an item |
| in_ready | output | 1 | Block can accept the offered item |
| in_data | input | 2 | Item value |
| out_valid | output | 1 | Head item is offered |
| out_ready | input | 1 | Consumer takes the offered item |
| out_data | output | 2 | Head item value |

## Verification
The hardest case to reach from the ports is a full queue whose pointers have already wrapped several times. It must then drain through the read path with a cell refill after each take, while inputs keep arriving in the same cycles as takes. The stimulus has three random phases. One is input-heavy, so the queue sits at capacity and both pointers wrap repeatedly. One is balanced, so output and input collide often. One is output-heavy, so the queue drains through the ring. Directed sequences pin down the 2-cycle windows of a cell write and a cell read, and the single-cycle bypass into an empty queue.

// File: rtl/crb_pkg.sv
// Shared types for the cached ring FIFO.
package crb_pkg;
    // Controller phases: idle, waiting on a cell write ack, waiting on a cell read ack
    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_WRITE = 2'd1,
        CTL_READ  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/crb_cell.sv
// One-place storage cell with request/acknowledge write and read channels.
// Assumes: requests are held until the acknowledge pulse; the cell strictly
// alternates a write then a read, acknowledging one cycle after each request.
module crb_cell #(
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic [DATA_W-1:0] wr_echo,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data
);
    logic              full;
    logic [DATA_W-1:0] store;

    // Accept a write while empty, a read while holding; pulse the matching ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            store  <= '0;
            wr_ack <= 1'b0;
            rd_ack <= 1'b0;
        end else begin
            wr_ack <= 1'b0;
            rd_ack <= 1'b0;
            if (!full && wr_req) begin
                store  <= wr_data;
                full   <= 1'b1;
                wr_ack <= 1'b1;
            end else if (full && rd_req && !rd_ack) begin
                full   <= 1'b0;
                rd_ack <= 1'b1;
            end
        end
    end

    // Echo and read data both present the held value
    always_comb begin
        wr_echo = store;
        rd_data = store;
    end

    // R10
    wr_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |-> !full);
    // R10
    rd_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |-> full);
    // R10
    ack_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !full |=> wr_ack);
endmodule

// File: rtl/crb_ptr.sv
// Ring pointer counting 1..RING_CELLS and wrapping back to 1.
// Assumes: adv is a single-cycle pulse per completed cell access.
module crb_ptr #(
    parameter int RING_CELLS = 3,
    parameter int PTR_W      = $clog2(RING_CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_CELLS);

    // Step the pointer on each advance, wrapping after the last cell
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= PTR_W'(1);
        else if (adv)
            ptr <= (ptr == LAST) ? PTR_W'(1) : ptr + PTR_W'(1);
    end

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != '0 && ptr <= LAST);
endmodule

// File: rtl/crb_ctrl.sv
// Controller: head register, occupancy count and cell access sequencing.
// Assumes: cells acknowledge one cycle after a held request; output takes
// priority over input, and input waits while a cell exchange is in flight.
module crb_ctrl
    import crb_pkg::*;
#(
    parameter int RING_CELLS = 3,
    parameter int DATA_W     = 2,
    parameter int PTR_W      = $clog2(RING_CELLS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [DATA_W-1:0]                in_data,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [DATA_W-1:0]                out_data,
    input  logic [PTR_W-1:0]                 wptr,
    input  logic [PTR_W-1:0]                 rptr,
    output logic                             wptr_adv,
    output logic                             rptr_adv,
    output logic [RING_CELLS-1:0]            cell_wr_req,
    output logic [DATA_W-1:0]                cell_wr_data,
    input  logic [RING_CELLS-1:0]            cell_wr_ack,
    input  logic [RING_CELLS-1:0][DATA_W-1:0] cell_wr_echo,
    output logic [RING_CELLS-1:0]            cell_rd_req,
    input  logic [RING_CELLS-1:0]            cell_rd_ack,
    input  logic [RING_CELLS-1:0][DATA_W-1:0] cell_rd_data
);
    localparam int CAP   = RING_CELLS + 1;
    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

    ctl_state_e        st;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] wbuf;
    logic              out_fire;
    logic              in_fire;
    logic              wr_ack_sel;
    logic              rd_ack_sel;
    logic [DATA_W-1:0] rd_sel_data;
    logic [DATA_W-1:0] echo_sel;

    // Port handshakes: offer head when idle and non-empty; output wins over input
    always_comb begin
        out_valid = (st == CTL_IDLE) && (count != '0);
        out_fire  = out_valid && out_ready;
        in_ready  = (st == CTL_IDLE) && (count < CAP_C) && !out_fire;
        in_fire   = in_valid && in_ready;
        out_data  = head;
    end

    // Address the cell under the relevant pointer and select its responses
    always_comb begin
        wr_ack_sel  = 1'b0;
        rd_ack_sel  = 1'b0;
        rd_sel_data = '0;
        echo_sel    = '0;
        for (int k = 0; k < RING_CELLS; k++) begin
            cell_wr_req[k] = (st == CTL_WRITE) && (wptr == PTR_W'(k + 1));
            cell_rd_req[k] = (st == CTL_READ)  && (rptr == PTR_W'(k + 1));
            if (wptr == PTR_W'(k + 1)) begin
                wr_ack_sel = cell_wr_ack[k];
                echo_sel   = cell_wr_echo[k];
            end
            if (rptr == PTR_W'(k + 1)) begin
                rd_ack_sel  = cell_rd_ack[k];
                rd_sel_data = cell_rd_data[k];
            end
        end
        cell_wr_data = wbuf;
        wptr_adv     = (st == CTL_WRITE) && wr_ack_sel;
        rptr_adv     = (st == CTL_READ)  && rd_ack_sel;
    end

    // Sequence transfers, cell exchanges, occupancy and the head register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CTL_IDLE;
            count <= '0;
            head  <= '0;
            wbuf  <= '0;
        end else begin
            unique case (st)
                CTL_IDLE: begin
                    if (out_fire) begin
                        if (count > CNT_W'(1)) st <= CTL_READ;
                        else                   count <= '0;
                    end else if (in_fire) begin
                        if (count == '0) begin
                            head  <= in_data;
                            count <= CNT_W'(1);
                        end else begin
                            wbuf <= in_data;
                            st   <= CTL_WRITE;
                        end
                    end
                end
                CTL_WRITE: begin
                    if (wr_ack_sel) begin
                        count <= count + CNT_W'(1);
                        st    <= CTL_IDLE;
                    end
                end
                CTL_READ: begin
                    if (rd_ack_sel) begin
                        head  <= rd_sel_data;
                        count <= count - CNT_W'(1);
                        st    <= CTL_IDLE;
                    end
                end
                default: st <= CTL_IDLE;
            endcase
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP_C);
    // R4
    empty_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && count == '0 |=> out_valid && out_data == $past(in_data));
    // R5
    take_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire |=> (st == CTL_READ) || (count == '0));
    // R9
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data));
    // R10
    single_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cell_wr_req, cell_rd_req}));
    // R10
    echo_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_adv |-> echo_sel == wbuf);
endmodule

// File: rtl/cached_ring_fifo.sv
// Top: cached ring FIFO with a head register plus a ring of one-place cells.
// Assumes: synchronous active-low reset; capacity is RING_CELLS + 1 items.
module cached_ring_fifo #(
    parameter int RING_CELLS = 3,
    parameter int DATA_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int PTR_W = $clog2(RING_CELLS + 1);

    logic [PTR_W-1:0]                  wptr;
    logic [PTR_W-1:0]                  rptr;
    logic                              wptr_adv;
    logic                              rptr_adv;
    logic [RING_CELLS-1:0]             cell_wr_req;
    logic [DATA_W-1:0]                 cell_wr_data;
    logic [RING_CELLS-1:0]             cell_wr_ack;
    logic [RING_CELLS-1:0][DATA_W-1:0] cell_wr_echo;
    logic [RING_CELLS-1:0]             cell_rd_req;
    logic [RING_CELLS-1:0]             cell_rd_ack;
    logic [RING_CELLS-1:0][DATA_W-1:0] cell_rd_data;

    crb_ctrl #(.RING_CELLS(RING_CELLS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .wptr         (wptr),
        .rptr         (rptr),
        .wptr_adv     (wptr_adv),
        .rptr_adv     (rptr_adv),
        .cell_wr_req  (cell_wr_req),
        .cell_wr_data (cell_wr_data),
        .cell_wr_ack  (cell_wr_ack),
        .cell_wr_echo (cell_wr_echo),
        .cell_rd_req  (cell_rd_req),
        .cell_rd_ack  (cell_rd_ack),
        .cell_rd_data (cell_rd_data)
    );

    crb_ptr #(.RING_CELLS(RING_CELLS), .PTR_W(PTR_W)) u_wptr (
        .clk (clk), .rst_n (rst_n), .adv (wptr_adv), .ptr (wptr)
    );

    crb_ptr #(.RING_CELLS(RING_CELLS), .PTR_W(PTR_W)) u_rptr (
        .clk (clk), .rst_n (rst_n), .adv (rptr_adv), .ptr (rptr)
    );

    // One storage cell per ring slot
    for (genvar g = 0; g < RING_CELLS; g++) begin : g_cell
        crb_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_req  (cell_wr_req[g]),
            .wr_data (cell_wr_data),
            .wr_ack  (cell_wr_ack[g]),
            .wr_echo (cell_wr_echo[g]),
            .rd_req  (cell_rd_req[g]),
            .rd_ack  (cell_rd_ack[g]),
            .rd_data (cell_rd_data[g])
        );
    end
endmodule

// File: tb/cached_ring_fifo_tb.sv
module cached_ring_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_data = 2'd1;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int q[$];

    cached_ring_fifo u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rand_val();
        return 1 + int'($urandom % 3);
    endfunction

    // Drive one cycle, check port rules against the reference queue, record transfers
    task automatic step(input bit iv, input logic [1:0] id, input bit ordy);
        @(negedge clk);
        in_valid  = iv;
        in_data   = id;
        out_ready = ordy;
        #1;
        if (q.size() == CAP) chk(!in_ready, "R3 in_ready at capacity", int'(in_ready), 0);
        if (q.size() == 0)   chk(!out_valid, "R5 out_valid when empty", int'(out_valid), 0);
        if (out_valid && out_ready) begin
            chk(!in_ready, "R6 in_ready during take", int'(in_ready), 0);
            if (q.size() > 0) begin
                chk(out_data == q[0], "R2 delivered value", int'(out_data), q[0]);
                void'(q.pop_front());
            end
        end
        if (in_valid && in_ready) q.push_back(int'(in_data));
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && (q.size() > 0 || out_valid); i++) step(1'b0, 2'd1, 1'b1);
    endtask

    // Run a random phase with given input and output probabilities in percent
    task automatic rand_phase(input int n, input int p_in, input int p_out);
        logic [1:0] prev_d;
        bit         prev_hold;
        for (int i = 0; i < n; i++) begin
            prev_hold = out_valid && !out_ready;
            prev_d    = out_data;
            step(($urandom % 100) < p_in, 2'(rand_val()), ($urandom % 100) < p_out);
            if (prev_hold) chk(out_data == prev_d, "R9 head stable", int'(out_data), int'(prev_d));
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        // R4: bypass into empty head
        step(1'b1, 2'd2, 1'b0);
        step(1'b0, 2'd1, 1'b0);
        chk(out_valid && out_data == 2'd2, "R4 bypass offered next cycle", int'(out_data), 2);

        // R8 / R10: write into ring takes two quiet cycles
        step(1'b1, 2'd3, 1'b0);
        step(1'b0, 2'd1, 1'b0);
        chk(!in_ready && !out_valid, "R8 busy cycle 1", int'(in_ready | out_valid), 0);
        step(1'b0, 2'd1, 1'b0);
        chk(!in_ready && !out_valid, "R8 R10 busy cycle 2", int'(in_ready | out_valid), 0);
        step(1'b0, 2'd1, 1'b0);
        chk(out_valid && out_data == 2'd2, "R8 head still offered", int'(out_data), 2);

        // R7 / R10: take with a refill takes two quiet cycles
        step(1'b0, 2'd1, 1'b1);
        step(1'b0, 2'd1, 1'b0);
        chk(!out_valid && !in_ready, "R7 refill cycle 1", int'(out_valid | in_ready), 0);
        step(1'b0, 2'd1, 1'b0);
        chk(!out_valid && !in_ready, "R7 R10 refill cycle 2", int'(out_valid | in_ready), 0);
        step(1'b0, 2'd1, 1'b0);
        chk(out_valid && out_data == 2'd3, "R7 next item offered", int'(out_data), 3);

        // R7: taking the last item needs no cell access
        step(1'b0, 2'd1, 1'b1);
        step(1'b0, 2'd1, 1'b0);
        chk(!out_valid && in_ready, "R7 last take leaves idle empty", int'(in_ready), 1);

        // R3: fill to capacity, refuse the fifth, accept after one take
        for (int i = 0; i < 30 && q.size() < CAP; i++) step(1'b1, 2'(1 + (i % 3)), 1'b0);
        chk(q.size() == CAP, "R3 filled to capacity", q.size(), CAP);
        for (int i = 0; i < 5; i++) step(1'b1, 2'd1, 1'b0);
        chk(q.size() == CAP, "R3 fifth item refused", q.size(), CAP);
        step(1'b0, 2'd1, 1'b1);
        for (int i = 0; i < 10 && q.size() < CAP; i++) step(1'b1, 2'd3, 1'b0);
        chk(q.size() == CAP, "R3 accepts after a take", q.size(), CAP);
        drain();

        // R6: simultaneous offer on both sides
        step(1'b1, 2'd1, 1'b0);
        step(1'b1, 2'd2, 1'b1);
        drain();

        // R2: random phases with wraps, collisions and drains
        rand_phase(3000, 80, 25);
        rand_phase(3000, 50, 50);
        rand_phase(3000, 25, 80);
        drain();
        chk(q.size() == 0 && !out_valid, "R2 all items delivered", q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule